// File: doc/BRIEF.md
# Stereo PDM Microphone Receiver

This block drives the shared bit clock for a pair of pulse-density-modulated microphones and pulls the two one-bit streams apart from their common data wire. One microphone is strapped as the right channel. It drives the wire while the bit clock is low. The other is strapped as the left channel and drives it while the clock is high. The receiver divides its system clock by an even ratio to make the bit clock. It then samples the data wire in the system clock domain just before each bit clock edge. At that moment the channel that owns the wire is still holding it.

Each channel appears as one data bit with a one-cycle valid strobe, once per bit period. The left and right strobes fall half a bit period apart. There is no back-pressure: the microphones cannot be paused, so the consumer must take every strobe in the cycle it is raised. A low enable parks the bit clock low, which puts the microphones to sleep. Raising enable starts a wake-up blanking window, and no strobe is issued until it has elapsed.

Parameters are checked at elaboration. The bit clock must land between 1.0 MHz and 3.3 MHz, and the ratio must be even and at least 4. Bits are passed through uninverted: a higher density of 1s means rising pressure.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While enabled, `mic_clk` is periodic with a period of exactly `CLK_DIV` system cycles, high for `CLK_DIV/2` and low for `CLK_DIV/2`.
- R2: When `enable` is sampled low, `mic_clk`, `right_valid` and `left_valid` are all low from the next cycle on, and stay low while `enable` stays low.
- R3: The right bit is the level of `mic_data` at the system edge where `mic_clk` rises. `right_bit` carries it uninverted (1 in gives 1 out), and `right_valid` pulses in the first cycle of the clock-high half.
- R4: The left bit is the level of `mic_data` at the system edge where `mic_clk` falls. `left_bit` carries it uninverted, and `left_valid` pulses in the first cycle of the clock-low half.
- R5: Each valid is a single-cycle pulse that occurs exactly once per bit period per channel. A left pulse follows a right pulse by `CLK_DIV/2` cycles, and the two pulses never coincide.
- R6: After `enable` rises, no strobe appears during the first `WAKE_CYCLES` cycles. The first strobe appears no later than `WAKE_CYCLES + CLK_DIV/2` cycles after the rise.
- R7: Lowering and raising `enable` again restarts the wake-up window from zero, with the same bounds as R6.
- R8: During and right after reset, `mic_clk`, `right_valid` and `left_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low parks the microphones |
| mic_data | input | 1 | Shared microphone data wire |
| mic_clk | output | 1 | Generated bit clock to both microphones |
| right_bit | output | 1 | Right channel bit, captured at the bit clock rise |
| right_valid | output | 1 | One-cycle strobe for `right_bit` |
| left_bit | output | 1 | Left channel bit, captured at the bit clock fall |
| left_valid | output | 1 | One-cycle strobe for `left_bit` |

## Verification
The bench builds the receiver with `SYS_FREQ_HZ` = 20 MHz, `CLK_DIV` = 8 and `WAKE_CYCLES` = 100. This gives a 2.5 MHz bit clock, inside the legal band, with only four system cycles per half period. The wake-up window, enable restarts and hundreds of bit periods therefore fit in a few thousand cycles. With halves this short, every capture point and strobe position sits within a cycle or two of an edge. A sampling point off by one cycle then lands on the other microphone's data.

// File: rtl/pdm_rx_pkg.sv
`timescale 1ns/1ps
package pdm_rx_pkg;
  // Channel identity; the value matches the strap level of the microphone.
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  localparam int unsigned NUM_CH = 2;

  // Legal bit clock band in Hz.
  localparam longint unsigned BCLK_MIN_HZ = 64'd1_000_000;
  localparam longint unsigned BCLK_MAX_HZ = 64'd3_300_000;

  function automatic chan_e chan_of(input int unsigned idx);
    return (idx == 0) ? CH_RIGHT : CH_LEFT;
  endfunction
endpackage

// File: rtl/pdm_bclk_gen.sv
`timescale 1ns/1ps
module pdm_bclk_gen #(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic bclk,
  output logic pre_rise,
  output logic pre_fall
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned PW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] LAST   = PW'(CLK_DIV - 1);
  localparam logic [PW-1:0] MID    = PW'(HALF);
  localparam logic [PW-1:0] MID_M1 = PW'(HALF - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    if (!enable)             phase_d = '0;
    else if (phase_q == LAST) phase_d = '0;
    else                     phase_d = phase_q + 1'b1;
  end

  // Edge of mic_clk happens on the same system edge that these flags are seen.
  assign pre_rise = enable && (phase_q == MID_M1);
  assign pre_fall = enable && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bclk    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bclk    <= enable && (phase_d >= MID);
    end
  end
endmodule

// File: rtl/pdm_wake_timer.sv
`timescale 1ns/1ps
module pdm_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic awake
);
  localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] LIMIT = WW'(WAKE_CYCLES);

  logic [WW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count_q <= '0;
    else if (!enable)         count_q <= '0;
    else if (count_q != LIMIT) count_q <= count_q + 1'b1;
  end

  assign awake = (count_q == LIMIT);
endmodule

// File: rtl/pdm_chan_capture.sv
`timescale 1ns/1ps
module pdm_chan_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic awake,
  input  logic line,
  output logic bit_q,
  output logic valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take && awake;
      if (take) bit_q <= line;
    end
  end
endmodule

// File: rtl/pdm_stereo_rx.sv
`timescale 1ns/1ps
module pdm_stereo_rx
  import pdm_rx_pkg::*;
#(
  parameter int unsigned SYS_FREQ_HZ = 100_000_000,
  parameter int unsigned CLK_DIV     = 40,
  parameter int unsigned WAKE_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic mic_data,
  output logic mic_clk,
  output logic right_bit,
  output logic right_valid,
  output logic left_bit,
  output logic left_valid
);
  localparam longint unsigned BCLK_HZ = longint'(SYS_FREQ_HZ) / longint'(CLK_DIV);

  generate
    if ((CLK_DIV % 2) != 0 || CLK_DIV < 4)
      $error("pdm_stereo_rx: CLK_DIV must be even and at least 4");
    if (BCLK_HZ < BCLK_MIN_HZ || BCLK_HZ > BCLK_MAX_HZ)
      $error("pdm_stereo_rx: bit clock outside 1.0-3.3 MHz");
    if (WAKE_CYCLES < 1)
      $error("pdm_stereo_rx: WAKE_CYCLES must be positive");
  endgenerate

  logic pre_rise, pre_fall, awake;
  logic [NUM_CH-1:0] ch_bit, ch_valid;

  pdm_bclk_gen #(.CLK_DIV(CLK_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .bclk(mic_clk), .pre_rise(pre_rise), .pre_fall(pre_fall)
  );

  pdm_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_n), .enable(enable), .awake(awake)
  );

  // Right drives while the clock is low: grab at the rise. Left is the mirror.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam chan_e CH = chan_of(c);
    logic take;
    assign take = (CH == CH_RIGHT) ? pre_rise : pre_fall;
    pdm_chan_capture u_cap (
      .clk(clk), .rst_n(rst_n), .take(take), .awake(awake),
      .line(mic_data), .bit_q(ch_bit[c]), .valid_q(ch_valid[c])
    );
  end

  assign right_bit   = ch_bit[0];
  assign right_valid = ch_valid[0];
  assign left_bit    = ch_bit[1];
  assign left_valid  = ch_valid[1];
endmodule

// File: rtl/pdm_stereo_rx_chk.sv
`timescale 1ns/1ps
module pdm_stereo_rx_chk #(
  parameter int unsigned WAKE_CYCLES = 1_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic mic_clk,
  input logic right_valid,
  input logic left_valid
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYCLES);

  logic [CW-1:0] on_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             on_cnt <= '0;
    else if (!enable)       on_cnt <= '0;
    else if (on_cnt != FULL) on_cnt <= on_cnt + 1'b1;
  end

  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !mic_clk); // R2
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !(right_valid || left_valid)); // R2
  AST_RIGHT_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) right_valid |-> (mic_clk && !$past(mic_clk))); // R3
  AST_LEFT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) left_valid |-> (!mic_clk && $past(mic_clk))); // R4
  AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) right_valid |=> !right_valid); // R5
  AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) left_valid |=> !left_valid); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(right_valid && left_valid)); // R5
  AST_WAKE_BLANK: assert property (@(posedge clk) disable iff (!rst_n) (right_valid || left_valid) |-> (on_cnt == FULL)); // R6
endmodule

bind pdm_stereo_rx pdm_stereo_rx_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mic_clk(mic_clk),
  .right_valid(right_valid), .left_valid(left_valid)
);

// File: tb/pdm_stereo_rx_test.sv
`timescale 1ns/1ps
module pdm_stereo_rx_test;
  localparam int CLK_PERIOD = 50;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int WAKE = 100;
  localparam int PERIODS_PER_VEC = 20;

  typedef struct packed {
    logic [15:0] lpat;
    logic [15:0] rpat;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{lpat: 16'hFFFF, rpat: 16'h0000},
    '{lpat: 16'h0000, rpat: 16'hFFFF},
    '{lpat: 16'hAAAA, rpat: 16'h5555},
    '{lpat: 16'hF0C3, rpat: 16'h1E69},
    '{lpat: 16'h8001, rpat: 16'h7FFE}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, mic_data = 1'b0;
  logic mic_clk, right_bit, right_valid, left_bit, left_valid;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0;
  int rcount = 0, lcount = 0;
  logic [15:0] cur_l = '0, cur_r = '0;
  logic [3:0] li = '0, ri = '0;
  logic exp_l = 1'b0, exp_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_stereo_rx #(.SYS_FREQ_HZ(20_000_000), .CLK_DIV(DIV), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mic_data(mic_data),
    .mic_clk(mic_clk), .right_bit(right_bit), .right_valid(right_valid),
    .left_bit(left_bit), .left_valid(left_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Microphone pair model: left drives after each rise, right after each fall.
  always @(posedge mic_clk) begin
    #15;
    exp_l = cur_l[li];
    mic_data = exp_l;
    li = li + 1'b1;
  end
  always @(negedge mic_clk) begin
    #15;
    exp_r = cur_r[ri];
    mic_data = exp_r;
    ri = ri + 1'b1;
  end

  // Stream monitor for R3/R4 data correctness.
  always @(negedge clk) begin
    if (mon_on && right_valid) begin
      rcount++;
      check(right_bit === exp_r, "R3 right bit", right_bit, exp_r);
    end
    if (mon_on && left_valid) begin
      lcount++;
      check(left_bit === exp_l, "R4 left bit", left_bit, exp_l);
    end
  end

  task automatic wake_check(input string req);
    int n = 0;
    bit seen = 1'b0;
    @(negedge clk) enable = 1'b1;
    while (!seen && n < WAKE + 4 * DIV) begin
      @(negedge clk);
      n++;
      if (right_valid || left_valid) seen = 1'b1;
    end
    check(seen && n >= WAKE + 1, {req, " no strobe in blanking"}, n, WAKE + 1);
    check(seen && n <= WAKE + HALF, {req, " first strobe late"}, n, WAKE + HALF);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit bad;
    int hi, lo, gap;
    // R8 reset state
    repeat (3) @(negedge clk);
    check(!mic_clk && !right_valid && !left_valid, "R8 reset outputs", {mic_clk, right_valid, left_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mic_clk && !right_valid && !left_valid, "R8 after release", {mic_clk, right_valid, left_valid}, 0);

    // R2 idle while disabled
    bad = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (mic_clk || right_valid || left_valid) bad = 1'b1;
    end
    check(!bad, "R2 disabled idle", bad, 0);

    // R6 wake window
    wake_check("R6");

    // R1 bit clock shape
    while (mic_clk) @(negedge clk);
    while (!mic_clk) @(negedge clk);
    hi = 0; while (mic_clk) begin hi++; @(negedge clk); end
    lo = 0; while (!mic_clk) begin lo++; @(negedge clk); end
    check(hi == HALF, "R1 high half", hi, HALF);
    check(lo == HALF, "R1 low half", lo, HALF);

    // R5 spacing and pulse width
    while (!right_valid) @(negedge clk);
    @(negedge clk);
    check(!right_valid, "R5 right pulse width", right_valid, 0);
    gap = 1; while (!left_valid) begin gap++; @(negedge clk); end
    check(gap == HALF, "R5 right-to-left gap", gap, HALF);
    @(negedge clk);
    check(!left_valid, "R5 left pulse width", left_valid, 0);
    gap = 1; while (!right_valid) begin gap++; @(negedge clk); end
    check(gap == HALF, "R5 left-to-right gap", gap, HALF);

    // R3/R4 vector table, R5 one strobe per period
    mon_on = 1'b1;
    for (int v = 0; v < 5; v++) begin
      cur_l = VECS[v].lpat;
      cur_r = VECS[v].rpat;
      repeat (2 * DIV) @(negedge clk);
      rcount = 0; lcount = 0;
      repeat (PERIODS_PER_VEC * DIV) @(negedge clk);
      check(rcount == PERIODS_PER_VEC, "R5 right strobes per vector", rcount, PERIODS_PER_VEC);
      check(lcount == PERIODS_PER_VEC, "R5 left strobes per vector", lcount, PERIODS_PER_VEC);
    end
    mon_on = 1'b0;

    // R2 disable mid-stream
    enable = 1'b0;
    @(negedge clk);
    check(!mic_clk && !right_valid && !left_valid, "R2 stop after disable", {mic_clk, right_valid, left_valid}, 0);
    bad = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (mic_clk || right_valid || left_valid) bad = 1'b1;
    end
    check(!bad, "R2 stays parked", bad, 0);

    // R7 restart of wake window
    wake_check("R7");

    // R7 short off pulse still restarts blanking
    @(negedge clk) enable = 1'b0;
    wake_check("R7 short off");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule